// File: doc/BRIEF.md
# Misaligned Access Byte Sequencer

This block takes one halfword, word or doubleword load or store whose address need not be aligned and carries it out as a chain of single-byte accesses on a narrow memory port, one byte per acknowledged access, stepping the address by one each time. Load bytes are gathered into a result in the byte order chosen by a static endianness input. Store bytes are picked from a copy of the store data taken when the request is accepted. A doubleword is moved as two words, the first at the base address and the second four bytes higher, into or out of a 64-bit register pair.

When the last byte is acknowledged the block reports completion with a one-cycle pulse that carries the load result, a fault flag and the new value of the base register, computed from the pre-index, up and writeback bits and the offset. If any byte access reports an error, the sequence stops there and completes with a fault and no base update.

A caller holds the request while `busy` is low; the request is taken on that edge and `busy` stays high until the completion cycle.

Top module: `unaligned_byte_seq`

## Requirements
- R1: A halfword request (size code 0) makes exactly 2 byte accesses, a word (size code 1) exactly 4, a doubleword (size code 2) exactly 8; the first is at the request address and each following one is one address higher.
- R2: With `big_endian` low, byte k of each word (or of the halfword) counted from its lowest address lands in result bits 8k+7:8k of that word, and store byte k is taken from the same bits.
- R3: With `big_endian` high, the lowest-addressed byte of a word lands in bits 31:24 of that word (bits 15:8 for a halfword) and each later byte one lane lower; stores take bytes from the same lanes.
- R4: A doubleword load places the word at the base address in `done_data[31:0]` and the word at base+4 in `done_data[63:32]`; a store takes them from `req_wdata` in the same way. Bits 63:32 are zero for smaller loads.
- R5: A halfword load with `req_signed` high copies result bit 15 into bits 31:16; with `req_signed` low bits 31:16 are zero.
- R6: If a byte access returns `mem_err` high with its acknowledge, no further byte access is issued and the next cycle shows `done` with `done_fault` high and `done_wb_en` low; an errored store byte is not written.
- R7: The effective offset is `req_offset` when `req_up` is high and its two's complement negation otherwise; `done_wb_addr` is the request address plus that offset when `req_pre` is low and the request address when it is high; `done_wb_en` is high when `req_pre` is low or `req_wb` is high.
- R8: While an access waits for `mem_ack`, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values; `busy` is high from the cycle after acceptance to the completion cycle, and a request raised while `busy` is high is ignored.
- R9: `done` is high for exactly one cycle, the cycle after the final acknowledge; `busy` is low in that cycle and a request presented then is accepted. After reset `busy`, `done` and `mem_req` are low.
- R10: Store bytes come from a copy of `req_wdata` taken at acceptance, so later changes of `req_wdata` do not affect the stored bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_endian | input | 1 | Static byte order select, 1 = big-endian |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_addr | input | AW | Byte address of the first byte |
| req_size | input | 2 | 0 halfword, 1 word, 2 doubleword |
| req_load | input | 1 | 1 = load, 0 = store |
| req_signed | input | 1 | Sign-extend a halfword load |
| req_pre | input | 1 | Pre-index: base update uses the unmodified address |
| req_up | input | 1 | Add the offset (1) or subtract it (0) |
| req_wb | input | 1 | Write the base back even when pre-indexed |
| req_offset | input | AW | Offset magnitude for the base update |
| req_wdata | input | 64 | Store data; low word first of the pair |
| busy | output | 1 | Sequence in progress |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | Byte access is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_ack | input | 1 | Byte access accepted and finished |
| mem_err | input | 1 | Byte access failed, valid with `mem_ack` |
| mem_rdata | input | 8 | Byte read, valid with `mem_ack` |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Sequence stopped on a byte error |
| done_data | output | 64 | Assembled load result |
| done_wb_en | output | 1 | Base register should be written |
| done_wb_addr | output | AW | New base register value |

## Verification
The completion pulse of one sequence and the acceptance of the next request can fall in the same cycle, since `busy` drops together with `done`. The bench provokes this by raising a new request in the very cycle it sees `done`, then judges that the first result is intact in that cycle, that `busy` rises in the next, and that the second transfer starts at its own address with a cleared result. A second overlap, an error acknowledge on what would otherwise be a mid-sequence byte, is judged by the byte count and the fault and writeback flags.

// File: rtl/ubs_pkg.sv
package ubs_pkg;
  localparam int WORD_BYTES = 4;
  localparam int PAIR_BYTES = 2 * WORD_BYTES;
  localparam int PAIR_BITS  = 8 * PAIR_BYTES;
  localparam int IDX_W      = $clog2(PAIR_BYTES);

  typedef enum logic [1:0] {
    SZ_HALF  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } size_e;

  // number of byte beats for a transfer size (reserved size behaves as a word)
  function automatic logic [IDX_W:0] beats_for(size_e sz);
    case (sz)
      SZ_HALF:  return (IDX_W+1)'(2);
      SZ_DWORD: return (IDX_W+1)'(PAIR_BYTES);
      default:  return (IDX_W+1)'(WORD_BYTES);
    endcase
  endfunction

  // byte lane of the 64-bit pair that beat number idx occupies
  function automatic logic [IDX_W-1:0] lane_for(size_e sz, logic be, logic [IDX_W-1:0] idx);
    if (!be)             return idx;
    else if (sz == SZ_HALF) return {2'b00, ~idx[0]};
    else                 return {idx[2], ~idx[1:0]};
  endfunction

  // final load value: sign extension of a signed halfword
  function automatic logic [PAIR_BITS-1:0] finish_load(logic [PAIR_BITS-1:0] acc, size_e sz, logic sgn);
    if (sz == SZ_HALF && sgn) return {32'd0, {16{acc[15]}}, acc[15:0]};
    else                      return acc;
  endfunction
endpackage

// File: rtl/ubs_ctrl.sv
module ubs_ctrl
  import ubs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W:0]   beats,
  input  logic             mem_ack,
  input  logic             mem_err,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             beat_ok,
  output logic             fin_ok,
  output logic             fin_err
);
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W:0]   beats_q;
  logic             last_beat;

  assign last_beat = ({1'b0, idx_q} == beats_q - (IDX_W+1)'(1));
  assign beat_ok   = busy_q & mem_ack & ~mem_err;
  assign fin_err   = busy_q & mem_ack & mem_err;
  assign fin_ok    = beat_ok & last_beat;
  assign busy      = busy_q;
  assign idx       = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      beats_q <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      idx_q   <= '0;
      beats_q <= beats;
    end else if (fin_ok || fin_err) begin
      busy_q  <= 1'b0;
    end else if (beat_ok) begin
      idx_q   <= idx_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/ubs_bytes.sv
module ubs_bytes
  import ubs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  size_e                size_in,
  input  logic                 signed_in,
  input  logic                 load_in,
  input  logic [PAIR_BITS-1:0] wdata_in,
  input  logic                 big_endian,
  input  logic                 beat_ok,
  input  logic [IDX_W-1:0]     idx,
  input  logic [7:0]           rdata,
  output logic [7:0]           wbyte,
  output logic [PAIR_BITS-1:0] result
);
  size_e                size_q;
  logic                 sign_q;
  logic                 load_q;
  logic [PAIR_BITS-1:0] store_q;
  logic [PAIR_BITS-1:0] acc_q;
  logic [IDX_W-1:0]     lane;

  assign lane   = lane_for(size_q, big_endian, idx);
  assign wbyte  = store_q[{lane, 3'b000} +: 8];
  assign result = finish_load(acc_q, size_q, sign_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q  <= SZ_HALF;
      sign_q  <= 1'b0;
      load_q  <= 1'b0;
      store_q <= '0;
      acc_q   <= '0;
    end else if (start) begin
      size_q  <= size_in;
      sign_q  <= signed_in;
      load_q  <= load_in;
      store_q <= wdata_in;
      acc_q   <= '0;
    end else if (beat_ok && load_q) begin
      acc_q[{lane, 3'b000} +: 8] <= rdata;
    end
  end
endmodule

// File: rtl/ubs_wb.sv
module ubs_wb #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  input  logic          pre,
  input  logic          up,
  input  logic          wbit,
  input  logic          fault,
  output logic          wb_en,
  output logic [AW-1:0] wb_addr
);
  function automatic logic [AW-1:0] signed_off(logic [AW-1:0] off, logic add);
    return add ? off : (~off + AW'(1));
  endfunction

  assign wb_addr = pre ? base : base + signed_off(offset, up);
  assign wb_en   = (~pre | wbit) & ~fault;
endmodule

// File: rtl/unaligned_byte_seq.sv
module unaligned_byte_seq
  import ubs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 big_endian,
  input  logic                 req_valid,
  input  logic [AW-1:0]        req_addr,
  input  logic [1:0]           req_size,
  input  logic                 req_load,
  input  logic                 req_signed,
  input  logic                 req_pre,
  input  logic                 req_up,
  input  logic                 req_wb,
  input  logic [AW-1:0]        req_offset,
  input  logic [PAIR_BITS-1:0] req_wdata,
  output logic                 busy,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [7:0]           mem_wdata,
  input  logic                 mem_ack,
  input  logic                 mem_err,
  input  logic [7:0]           mem_rdata,
  output logic                 done,
  output logic                 done_fault,
  output logic [PAIR_BITS-1:0] done_data,
  output logic                 done_wb_en,
  output logic [AW-1:0]        done_wb_addr
);
  // internal events, named for the checker
  logic             start;
  logic             beat_ok;
  logic             fin_ok;
  logic             fin_err;
  logic [IDX_W-1:0] idx;
  logic             wb_en_c;
  logic [AW-1:0]    wb_addr_c;

  logic [AW-1:0] addr_q;
  logic [AW-1:0] off_q;
  logic          load_q, pre_q, up_q, wbit_q;
  logic          done_q, fault_q, wb_en_q;
  logic [AW-1:0] wb_addr_q;

  assign start = req_valid & ~busy;

  ubs_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .beats   (beats_for(size_e'(req_size))),
    .mem_ack (mem_ack),
    .mem_err (mem_err),
    .busy    (busy),
    .idx     (idx),
    .beat_ok (beat_ok),
    .fin_ok  (fin_ok),
    .fin_err (fin_err)
  );

  ubs_bytes u_bytes (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .size_in    (size_e'(req_size)),
    .signed_in  (req_signed),
    .load_in    (req_load),
    .wdata_in   (req_wdata),
    .big_endian (big_endian),
    .beat_ok    (beat_ok),
    .idx        (idx),
    .rdata      (mem_rdata),
    .wbyte      (mem_wdata),
    .result     (done_data)
  );

  ubs_wb #(.AW(AW)) u_wb (
    .base    (addr_q),
    .offset  (off_q),
    .pre     (pre_q),
    .up      (up_q),
    .wbit    (wbit_q),
    .fault   (fin_err),
    .wb_en   (wb_en_c),
    .wb_addr (wb_addr_c)
  );

  assign mem_req  = busy;
  assign mem_we   = ~load_q;
  assign mem_addr = addr_q + {{(AW-IDX_W){1'b0}}, idx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      off_q  <= '0;
      load_q <= 1'b1;
      pre_q  <= 1'b0;
      up_q   <= 1'b0;
      wbit_q <= 1'b0;
    end else if (start) begin
      addr_q <= req_addr;
      off_q  <= req_offset;
      load_q <= req_load;
      pre_q  <= req_pre;
      up_q   <= req_up;
      wbit_q <= req_wb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      wb_en_q   <= 1'b0;
      wb_addr_q <= '0;
    end else begin
      done_q <= fin_ok | fin_err;
      if (fin_ok || fin_err) begin
        fault_q   <= fin_err;
        wb_en_q   <= wb_en_c;
        wb_addr_q <= wb_addr_c;
      end
    end
  end

  assign done         = done_q;
  assign done_fault   = fault_q;
  assign done_wb_en   = wb_en_q;
  assign done_wb_addr = wb_addr_q;
endmodule

// File: rtl/ubs_checks.sv
module ubs_checks #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wdata,
  input logic          mem_ack,
  input logic          mem_err,
  input logic          done,
  input logic          done_fault,
  input logic          done_wb_en,
  input logic          fin_err
);
  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_err) |=> (!mem_req || mem_addr == $past(mem_addr) + AW'(1)));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_err_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin_err |=> (done && done_fault && !done_wb_en && !mem_req));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind unaligned_byte_seq ubs_checks #(.AW(AW)) u_checks (.*);

// File: tb/unaligned_byte_seq_bench.sv
`timescale 1ns/1ps
module unaligned_byte_seq_bench;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          big_endian = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'd0;
  logic          req_load = 1'b0, req_signed = 1'b0;
  logic          req_pre = 1'b0, req_up = 1'b0, req_wb = 1'b0;
  logic [AW-1:0] req_offset = '0;
  logic [63:0]   req_wdata = '0;
  logic          busy, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          mem_ack = 1'b0, mem_err = 1'b0;
  logic [7:0]    mem_rdata = '0;
  logic          done, done_fault, done_wb_en;
  logic [63:0]   done_data;
  logic [AW-1:0] done_wb_addr;

  unaligned_byte_seq #(.AW(AW)) u_unaligned_byte_seq (.*);

  always #2 clk = ~clk;

  int vectors = 0;
  int misses  = 0;

  // byte memory model with latency, error injection and an access log
  logic [7:0] mem [256];
  int   lat = 0, wcnt = 0, nacc = 0, stall_bad = 0;
  logic err_en = 1'b0;
  logic [7:0] err_addr = '0, hold_addr = '0;
  logic [7:0] alog [16];

  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0; mem_err = 1'b0; wcnt = 0;
      end else if (mem_req) begin
        if (wcnt == 0) hold_addr = mem_addr[7:0];
        else if (mem_addr[7:0] != hold_addr) stall_bad++;
        if (wcnt >= lat) begin
          mem_ack   = 1'b1;
          mem_rdata = mem[mem_addr[7:0]];
          mem_err   = err_en && (mem_addr[7:0] == err_addr);
          if (mem_we && !mem_err) mem[mem_addr[7:0]] = mem_wdata;
          if (nacc < 16) alog[nacc] = mem_addr[7:0];
          nacc++;
        end else wcnt++;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] le_word(int a);
    return {mem[8'(a+3)], mem[8'(a+2)], mem[8'(a+1)], mem[8'(a)]};
  endfunction
  function automatic logic [31:0] be_word(int a);
    return {mem[8'(a)], mem[8'(a+1)], mem[8'(a+2)], mem[8'(a+3)]};
  endfunction

  logic [63:0]   r_data;
  logic          r_fault, r_wb_en;
  logic [AW-1:0] r_wb_addr;

  task automatic present(input logic [AW-1:0] a, input logic [1:0] sz, input logic ld, sg,
                         input logic p, u, w, input logic [AW-1:0] off, input logic [63:0] wd);
    req_addr = a; req_size = sz; req_load = ld; req_signed = sg;
    req_pre = p; req_up = u; req_wb = w; req_offset = off; req_wdata = wd;
    req_valid = 1'b1;
  endtask

  task automatic run_op(input logic [AW-1:0] a, input logic [1:0] sz, input logic ld, sg,
                        input logic p, u, w, input logic [AW-1:0] off, input logic [63:0] wd);
    @(negedge clk);
    nacc = 0;
    present(a, sz, ld, sg, p, u, w, off, wd);
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = ~wd;   // R10: caller changes its data during the sequence
    while (!done) @(negedge clk);
    r_data = done_data; r_fault = done_fault; r_wb_en = done_wb_en; r_wb_addr = done_wb_addr;
    @(negedge clk);
    chk("R9 done lasts one cycle", 64'(done), 64'd0);
  endtask

  task automatic t_reset;
    chk("R9 reset busy", 64'(busy), 64'd0);
    chk("R9 reset done", 64'(done), 64'd0);
    chk("R9 reset mem_req", 64'(mem_req), 64'd0);
  endtask

  task automatic t_le_word;
    big_endian = 1'b0;
    run_op(32'h13, 2'd1, 1, 0, 1, 1, 0, 32'h0, 64'h0);
    chk("R2 little-endian word load", r_data, {32'd0, le_word(32'h13)});
    chk("R1 word beat count", 64'(nacc), 64'd4);
    chk("R1 first address", 64'(alog[0]), 64'h13);
    chk("R1 last address", 64'(alog[3]), 64'h16);
    chk("R7 pre-indexed no writeback", 64'(r_wb_en), 64'd0);
  endtask

  task automatic t_be_word;
    big_endian = 1'b1;
    run_op(32'h31, 2'd1, 1, 0, 1, 1, 0, 32'h0, 64'h0);
    chk("R3 big-endian word load", r_data, {32'd0, be_word(32'h31)});
    big_endian = 1'b0;
  endtask

  task automatic t_half;
    mem[8'h41] = 8'h34; mem[8'h42] = 8'h92; mem[8'h43] = 8'h01;
    big_endian = 1'b0;
    run_op(32'h41, 2'd0, 1, 1, 1, 1, 0, 32'h0, 64'h0);
    chk("R5 signed LE halfword", r_data, 64'h00000000_FFFF9234);
    chk("R1 halfword beat count", 64'(nacc), 64'd2);
    run_op(32'h41, 2'd0, 1, 0, 1, 1, 0, 32'h0, 64'h0);
    chk("R5 unsigned LE halfword", r_data, 64'h00000000_00009234);
    big_endian = 1'b1;
    run_op(32'h42, 2'd0, 1, 1, 1, 1, 0, 32'h0, 64'h0);
    chk("R3 R5 signed BE halfword", r_data, 64'h00000000_FFFF9201);
    big_endian = 1'b0;
  endtask

  task automatic t_dword;
    big_endian = 1'b0;
    run_op(32'h51, 2'd2, 1, 0, 1, 1, 0, 32'h0, 64'h0);
    chk("R4 LE doubleword load", r_data, {le_word(32'h55), le_word(32'h51)});
    chk("R1 doubleword beat count", 64'(nacc), 64'd8);
    chk("R1 doubleword last address", 64'(alog[7]), 64'h58);
    big_endian = 1'b1;
    run_op(32'h51, 2'd2, 1, 0, 1, 1, 0, 32'h0, 64'h0);
    chk("R4 BE doubleword load", r_data, {be_word(32'h55), be_word(32'h51)});
    big_endian = 1'b0;
  endtask

  task automatic t_store;
    big_endian = 1'b0;
    run_op(32'h61, 2'd1, 0, 0, 1, 1, 0, 32'h0, 64'h0BAD_F00D_A1B2_C3D4);
    chk("R2 R10 LE word store", 64'(le_word(32'h61)), 64'hA1B2C3D4);
    big_endian = 1'b1;
    run_op(32'h71, 2'd2, 0, 0, 1, 1, 0, 32'h0, 64'h1122_3344_5566_7788);
    chk("R3 R4 BE store low word", 64'(be_word(32'h71)), 64'h55667788);
    chk("R3 R4 BE store high word", 64'(be_word(32'h75)), 64'h11223344);
    big_endian = 1'b0;
  endtask

  task automatic t_error;
    err_en = 1'b1; err_addr = 8'h83;
    run_op(32'h81, 2'd1, 1, 0, 0, 1, 1, 32'h8, 64'h0);
    chk("R6 fault flag", 64'(r_fault), 64'd1);
    chk("R6 no writeback on fault", 64'(r_wb_en), 64'd0);
    chk("R6 stops at failing byte", 64'(nacc), 64'd3);
    mem[8'h93] = 8'h5A;
    err_addr = 8'h92;
    run_op(32'h91, 2'd1, 0, 0, 1, 1, 0, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R6 store beats after error", 64'(nacc), 64'd2);
    chk("R6 byte after error untouched", 64'(mem[8'h93]), 64'h5A);
    err_en = 1'b0;
  endtask

  task automatic t_wb;
    run_op(32'h1000_00A1, 2'd1, 1, 0, 0, 1, 0, 32'h10, 64'h0);
    chk("R7 post-index add addr", 64'(r_wb_addr), 64'h1000_00B1);
    chk("R7 post-index enables", 64'(r_wb_en), 64'd1);
    run_op(32'h1000_00A1, 2'd1, 1, 0, 0, 0, 0, 32'h10, 64'h0);
    chk("R7 post-index subtract", 64'(r_wb_addr), 64'h1000_0091);
    run_op(32'h1000_00A1, 2'd0, 1, 0, 1, 0, 1, 32'h10, 64'h0);
    chk("R7 pre-index writeback addr", 64'(r_wb_addr), 64'h1000_00A1);
    chk("R7 pre-index writeback enable", 64'(r_wb_en), 64'd1);
  endtask

  task automatic t_stall;
    lat = 3; stall_bad = 0;
    @(negedge clk);
    nacc = 0;
    present(32'hC1, 2'd1, 1, 0, 1, 1, 0, 32'h0, 64'h0);
    @(negedge clk);
    chk("R8 busy after accept", 64'(busy), 64'd1);
    req_addr = 32'hE0;              // R8: request while busy, must be ignored
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    chk("R8 stalled load data", done_data, {32'd0, le_word(32'hC1)});
    repeat (3) @(negedge clk);
    chk("R8 ignored request started nothing", 64'(mem_req), 64'd0);
    chk("R8 beats with ignored request", 64'(nacc), 64'd4);
    chk("R8 last address unchanged", 64'(alog[3]), 64'hC4);
    chk("R8 address held while waiting", 64'(stall_bad), 64'd0);
    lat = 0;
  endtask

  task automatic t_b2b;
    big_endian = 1'b0;
    @(negedge clk);
    nacc = 0;
    present(32'hD1, 2'd1, 1, 0, 1, 1, 0, 32'h0, 64'h0);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    chk("R9 busy low with done", 64'(busy), 64'd0);
    chk("R9 first result in done cycle", done_data, {32'd0, le_word(32'hD1)});
    present(32'hD6, 2'd0, 1, 0, 1, 1, 0, 32'h0, 64'h0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 accepted in done cycle", 64'(busy), 64'd1);
    while (!done) @(negedge clk);
    chk("R9 second result", done_data, {48'd0, mem[8'hD7], mem[8'hD6]});
    chk("R9 total beats", 64'(nacc), 64'd6);
    chk("R9 second start address", 64'(alog[4]), 64'hD6);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_le_word();
    t_be_word();
    t_half();
    t_dword();
    t_store();
    t_error();
    t_wb();
    t_stall();
    t_b2b();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++; misses++;
    $display("FAIL R9 watchdog actual=hung expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule